// File: doc/BRIEF.md
# Multiple and String Memory-Access Cracker

This block takes one load/store-multiple or load/store-string request and turns it into a sequence of single memory accesses. Each access is either a 32-bit word or an 8-bit byte. Each carries an address, a size, the register it reads or fills, and the byte lane inside that register. A request gives a base address, a first register, a count and a direction. For a string the count is in bytes. For a multiple it is in registers.

For a string, the block first tries whole words and then emits the leftover `count mod 4` bytes one at a time. Memory answers each accepted access with an alignment-fault flag. A fault during this word-first attempt discards it, and the whole string is issued again from byte 0, one byte per access. A multiple is always issued as words. When the request ends, the block pulses `done` and reports the microword count of the cracking method that finished. `err` is raised alongside `done` if the request could not complete.

Top module: `lsm_cracker`

## Requirements
- R1: A multiple of N registers issues exactly N word accesses (acc_size=1). Access j has address base+4j, register (first+j) mod 32 and lane 0. No byte accesses are issued.
- R2: A string of B bytes issues floor(B/4) word accesses at base+4j to register first+j, then B mod 4 byte accesses (acc_size=0). Byte i uses address base+i, register first+floor(i/4) mod 32 and lane i mod 4, where lane 0 is bits 31:24 of the register. Word accesses always carry lane 0.
- R3: If any access in the word-first attempt of a string is acknowledged with acc_fault=1, the attempt is dropped. The block then issues B byte accesses for i=0..B-1 with the byte addressing of R2.
- R4: A fault in the byte retry, or any fault during a multiple, ends the request. `err` goes to 1 in the `done` cycle and no further access is issued. When no such fault occurs, `err` is 0.
- R5: A count of zero produces no access, and `done` rises in the cycle after the request is accepted.
- R6: `done` is a single-cycle pulse in the cycle after the handshake of the final access.
- R7: While `done` is high, `mw_count` shows the microword count. For a multiple it is 2+N, and req_indexed is ignored. For a string that completed word-first it is floor(B/4)+2·(B mod 4). For a string that used the byte retry it is 2·B. An indexed string adds 4 to either string value.
- R8: While acc_valid=1 and acc_ready=0, the access fields stay unchanged into the next cycle.
- R9: req_ready is 1 only when the block is idle, never while an access is offered. After reset the block is idle with acc_valid=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_store | input | 1 | 1 = store, 0 = load |
| req_string | input | 1 | 1 = string (count in bytes), 0 = multiple (count in registers) |
| req_indexed | input | 1 | Register-indexed string form (microword adjustment only) |
| req_base | input | ADDR_W | Base address |
| req_first_reg | input | REG_W | First register |
| req_count | input | CNT_W | Byte or register count |
| acc_valid | output | 1 | Access offered |
| acc_ready | input | 1 | Memory takes the access |
| acc_fault | input | 1 | Alignment fault reported with the handshake |
| acc_store | output | 1 | Direction of the access |
| acc_size | output | 1 | 1 = word, 0 = byte |
| acc_addr | output | ADDR_W | Access address |
| acc_reg | output | REG_W | Register index |
| acc_lane | output | 2 | Byte lane, 0 = most significant |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Request failed, valid with done |
| mw_count | output | CNT_W+2 | Microword count, valid with done |

## Verification
The properties assume that `acc_fault` only matters in a cycle where an access is both offered and taken. They also assume that `req_valid` is driven only as a pulse while `req_ready` is high. The bench's memory model meets the first assumption. It raises the fault only for an offered word at an unaligned address, or for every offered access in the forced-fault cases, and it holds the fault low at all other times. Requests are issued only from the idle state and are withdrawn after one cycle. A separate pattern that stalls `acc_ready` exercises the hold rule.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } crk_state_t;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_t;

    typedef struct packed {
        logic store;
        logic is_str;
        logic indexed;
    } req_kind_t;

    localparam int unsigned WORD_BYTES = 4;

    function automatic logic [2:0] step_of(input acc_size_t sz);
        return (sz == SZ_WORD) ? 3'd4 : 3'd1;
    endfunction

endpackage

// File: rtl/lsm_acc_gen.sv
module lsm_acc_gen
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5,
    localparam int TOT_W = CNT_W + 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  first_reg,
    input  logic [TOT_W-1:0]  pos,
    input  logic [TOT_W-1:0]  total,
    input  logic              byte_mode,
    output logic [ADDR_W-1:0] addr,
    output acc_size_t         size,
    output logic [REG_W-1:0]  reg_idx,
    output logic [1:0]        lane,
    output logic [2:0]        step,
    output logic              last
);

    logic [TOT_W-1:0] remaining;
    logic             use_word;

    always_comb begin
        remaining = total - pos;
        use_word  = !byte_mode && (remaining >= TOT_W'(WORD_BYTES));
        size      = use_word ? SZ_WORD : SZ_BYTE;
        step      = step_of(size);
        addr      = base + ADDR_W'(pos);
        reg_idx   = first_reg + REG_W'(pos >> 2);
        lane      = use_word ? 2'b00 : pos[1:0];
        last      = ((pos + TOT_W'(step)) == total);
    end

endmodule

// File: rtl/lsm_mw_calc.sv
module lsm_mw_calc #(
    parameter int CNT_W = 8,
    localparam int MW_W = CNT_W + 2
) (
    input  logic [CNT_W-1:0] count,
    input  logic             is_str,
    input  logic             indexed,
    input  logic             byte_mode,
    output logic [MW_W-1:0]  mw
);

    logic [MW_W-1:0] cnt_x;
    logic [MW_W-1:0] core;

    always_comb begin
        cnt_x = MW_W'(count);
        if (byte_mode)
            core = cnt_x << 1;
        else
            core = (cnt_x >> 2) + MW_W'({count[1:0], 1'b0});
        if (!is_str)
            mw = cnt_x + MW_W'(2);
        else
            mw = core + (indexed ? MW_W'(4) : MW_W'(0));
    end

endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5,
    localparam int TOT_W = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_kind_t         req_kind,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [REG_W-1:0]  req_first,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              acc_ready,
    input  logic              acc_fault,
    input  logic [2:0]        step,
    input  logic              last,
    output logic              req_ready,
    output logic              running,
    output logic              done,
    output logic              err,
    output req_kind_t         kind_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [REG_W-1:0]  first_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [TOT_W-1:0]  total_q,
    output logic [TOT_W-1:0]  pos_q,
    output logic              byte_mode_q
);

    crk_state_t       state_q;
    logic             err_q;
    logic [TOT_W-1:0] req_total;

    assign req_total = req_kind.is_str ? TOT_W'(req_count) : {req_count, 2'b00};
    assign req_ready = (state_q == ST_IDLE);
    assign running   = (state_q == ST_RUN);
    assign done      = (state_q == ST_FIN);
    assign err       = done && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            err_q       <= 1'b0;
            kind_q      <= '0;
            base_q      <= '0;
            first_q     <= '0;
            count_q     <= '0;
            total_q     <= '0;
            pos_q       <= '0;
            byte_mode_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q      <= req_kind;
                        base_q      <= req_base;
                        first_q     <= req_first;
                        count_q     <= req_count;
                        total_q     <= req_total;
                        pos_q       <= '0;
                        byte_mode_q <= 1'b0;
                        err_q       <= 1'b0;
                        state_q     <= (req_total == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (acc_ready) begin
                        if (acc_fault) begin
                            if (kind_q.is_str && !byte_mode_q) begin
                                byte_mode_q <= 1'b1;
                                pos_q       <= '0;
                            end else begin
                                err_q   <= 1'b1;
                                state_q <= ST_FIN;
                            end
                        end else if (last) begin
                            state_q <= ST_FIN;
                        end else begin
                            pos_q <= pos_q + TOT_W'(step);
                        end
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lsm_cracker.sv
module lsm_cracker
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5,
    localparam int TOT_W = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_string,
    input  logic              req_indexed,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [REG_W-1:0]  req_first_reg,
    input  logic [CNT_W-1:0]  req_count,
    output logic              acc_valid,
    input  logic              acc_ready,
    input  logic              acc_fault,
    output logic              acc_store,
    output logic              acc_size,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [REG_W-1:0]  acc_reg,
    output logic [1:0]        acc_lane,
    output logic              done,
    output logic              err,
    output logic [CNT_W+1:0]  mw_count
);

    req_kind_t         kind_in;
    req_kind_t         kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [REG_W-1:0]  first_q;
    logic [CNT_W-1:0]  count_q;
    logic [TOT_W-1:0]  total_q;
    logic [TOT_W-1:0]  pos_q;
    logic              byte_mode_q;
    logic              running;
    logic [2:0]        step;
    logic              last;
    acc_size_t         size_e;

    assign kind_in = '{store: req_store, is_str: req_string, indexed: req_indexed};

    lsm_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_kind    (kind_in),
        .req_base    (req_base),
        .req_first   (req_first_reg),
        .req_count   (req_count),
        .acc_ready   (acc_ready),
        .acc_fault   (acc_fault),
        .step        (step),
        .last        (last),
        .req_ready   (req_ready),
        .running     (running),
        .done        (done),
        .err         (err),
        .kind_q      (kind_q),
        .base_q      (base_q),
        .first_q     (first_q),
        .count_q     (count_q),
        .total_q     (total_q),
        .pos_q       (pos_q),
        .byte_mode_q (byte_mode_q)
    );

    lsm_acc_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_gen (
        .base      (base_q),
        .first_reg (first_q),
        .pos       (pos_q),
        .total     (total_q),
        .byte_mode (byte_mode_q),
        .addr      (acc_addr),
        .size      (size_e),
        .reg_idx   (acc_reg),
        .lane      (acc_lane),
        .step      (step),
        .last      (last)
    );

    lsm_mw_calc #(.CNT_W(CNT_W)) u_mw (
        .count     (count_q),
        .is_str    (kind_q.is_str),
        .indexed   (kind_q.indexed),
        .byte_mode (byte_mode_q),
        .mw        (mw_count)
    );

    assign acc_valid = running;
    assign acc_store = kind_q.store;
    assign acc_size  = size_e;

endmodule

// File: rtl/lsm_cracker_chk.sv
module lsm_cracker_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CNT_W-1:0]  req_count,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              acc_size,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [REG_W-1:0]  acc_reg,
    input logic [1:0]        acc_lane,
    input logic              done,
    input logic              err
);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_reg)
                                    && $stable(acc_lane) && $stable(acc_size));

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> !req_ready);

    assert_word_lane_R2: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_size |-> acc_lane == 2'b00);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> done && !acc_valid);

    assert_zero_count_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_count == '0 |=> done && !acc_valid);

endmodule

bind lsm_cracker lsm_cracker_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_count (req_count),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_reg   (acc_reg),
    .acc_lane  (acc_lane),
    .done      (done),
    .err       (err)
);

// File: tb/tb_lsm_cracker.sv
`timescale 1ns/1ps
module tb_lsm_cracker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_store, req_string, req_indexed;
    logic [31:0] req_base;
    logic [4:0]  req_first_reg;
    logic [7:0]  req_count;
    logic        acc_valid, acc_ready, acc_fault, acc_store, acc_size;
    logic [31:0] acc_addr;
    logic [4:0]  acc_reg;
    logic [1:0]  acc_lane;
    logic        done, err;
    logic [9:0]  mw_count;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        int addr;
        int size;
        int rg;
        int lane;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lsm_cracker dut (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: expected access list for one request.
    task automatic plan(input bit is_str, input int base, input int first, input int count,
                        input bit fault_all, output bit exp_err);
        int total;
        int p;
        bit faulted;
        exp_t e;
        q.delete();
        exp_err = 0;
        faulted = 0;
        total = is_str ? count : count * 4;
        p = 0;
        while (p < total && !faulted) begin
            if (total - p >= 4) e = '{base + p, 1, (first + p / 4) % 32, 0};
            else                e = '{base + p, 0, (first + p / 4) % 32, p % 4};
            q.push_back(e);
            if (fault_all || (e.size == 1 && (e.addr % 4) != 0)) faulted = 1;
            p += (e.size == 1) ? 4 : 1;
        end
        if (faulted) begin
            if (!is_str) exp_err = 1;
            else begin
                for (int i = 0; i < total; i++) begin
                    q.push_back('{base + i, 0, (first + i / 4) % 32, i % 4});
                    if (fault_all) begin
                        exp_err = 1;
                        break;
                    end
                end
            end
        end
    endtask

    task automatic run(input string tag, input bit store, input bit is_str, input bit idx,
                       input int base, input int first, input int count,
                       input bit fault_all, input bit stall, input int exp_mw);
        bit exp_err;
        bit exp_done;
        bit finished;
        bit rdy;
        plan(is_str, base, first, count, fault_all, exp_err);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", {tag, " idle before request"}, int'(req_ready), 1);
        req_store = store; req_string = is_str; req_indexed = idx;
        req_base = base; req_first_reg = first[4:0]; req_count = count[7:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_done = (q.size() == 0);
        finished = 0;
        for (int c = 0; c < 3000; c++) begin
            chk(done == exp_done, "R6", {tag, " done timing"}, int'(done), int'(exp_done));
            if (done) begin
                chk(err == exp_err, "R4", {tag, " err"}, int'(err), int'(exp_err));
                chk(int'(mw_count) == exp_mw, "R7", {tag, " microwords"}, int'(mw_count), exp_mw);
                chk(q.size() == 0, tag, "missing accesses", q.size(), 0);
                acc_ready = 1'b0;
                acc_fault = 1'b0;
                finished = 1;
                break;
            end
            chk(req_ready == 1'b0, "R9", {tag, " busy"}, int'(req_ready), 0);
            chk(acc_valid == (q.size() > 0), tag, "acc_valid", int'(acc_valid), int'(q.size() > 0));
            if (acc_valid && q.size() > 0) begin
                chk(int'(acc_addr) == q[0].addr, tag, "addr", int'(acc_addr), q[0].addr);
                chk(int'(acc_size) == q[0].size, tag, "size", int'(acc_size), q[0].size);
                chk(int'(acc_reg) == q[0].rg, tag, "reg", int'(acc_reg), q[0].rg);
                chk(int'(acc_lane) == q[0].lane, tag, "lane", int'(acc_lane), q[0].lane);
                chk(acc_store == store, tag, "store", int'(acc_store), int'(store));
            end
            rdy = !stall || (cyc % 3 != 1);
            acc_ready = rdy;
            acc_fault = acc_valid && (fault_all || (acc_size && acc_addr[1:0] != 2'b00));
            if (acc_valid && rdy && q.size() > 0) begin
                void'(q.pop_front());
                if (q.size() == 0) exp_done = 1;
            end
            @(negedge clk);
            if (stall && acc_valid && !rdy) begin
                // R8: the held access is compared against the same queue head next cycle
            end
        end
        if (!finished) chk(1'b0, tag, "request never finished", 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_store = 1'b0; req_string = 1'b0; req_indexed = 1'b0;
        req_base = '0; req_first_reg = '0; req_count = '0;
        acc_ready = 1'b0; acc_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset req_ready", int'(req_ready), 1);
        chk(acc_valid == 1'b0, "R9", "reset acc_valid", int'(acc_valid), 0);
        chk(done == 1'b0, "R9", "reset done", int'(done), 0);

        // R1 and R7: multiple wrapping 31->0, indexed flag ignored, mw = 2+5
        run("R1", 0, 0, 1, 32'h100, 29, 5, 0, 0, 7);
        // R2 and R8: string of 11 bytes with stalls, mw = 2 + 2*3
        run("R2", 1, 1, 0, 32'h200, 3, 11, 0, 1, 8);
        // R3: unaligned string, word fault then byte retry, mw = 2*7 + 4
        run("R3", 0, 1, 1, 32'h203, 10, 7, 0, 0, 18);
        // R5: empty string, mw = 0
        run("R5", 0, 1, 0, 32'h400, 0, 0, 0, 0, 0);
        // R4: string where the byte retry also faults, mw = 2*6
        run("R4", 1, 1, 0, 32'h300, 0, 6, 1, 0, 12);
        // R4: faulting multiple, mw = 2+3
        run("R4", 0, 0, 0, 32'h380, 4, 3, 1, 0, 5);
        // R2: bytes only, register 31, mw = 6
        run("R2", 0, 1, 0, 32'h500, 31, 3, 0, 0, 6);
        // R7 and R8: indexed string of two words with stalls, mw = 2 + 4
        run("R7", 1, 1, 1, 32'h600, 30, 8, 0, 1, 6);
        // R5: empty multiple, mw = 2
        run("R5", 1, 0, 0, 32'h700, 7, 0, 0, 0, 2);
        // R3 and R8: unaligned string retry under stalls, mw = 2*5
        run("R3", 1, 1, 0, 32'h701, 12, 5, 0, 1, 10);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule